// File: doc/BRIEF.md
# DDR SDRAM Mode Register Unit

This block is the configuration register on the device side of a DDR SDRAM command decoder. When the decoder signals a mode-load command and both bank-select inputs are low, the block captures the twelve address bits together with the two bank bits as a 14-bit mode word. It then presents the decoded settings to the rest of the device: burst length, burst ordering and the CAS latency code.

The block checks each load before and after storing it. A load is refused if any bank is still open or if a bank-select bit is set. A stored word that contains an unsupported code in any field is kept, but it is marked invalid. If the DLL-reset bit is set in the loaded word, the block emits a single-cycle pulse and that bit is not retained.

Every accepted load starts a lockout of a programmable length. During the lockout a busy flag is high. Any command that arrives while busy is dropped and raises a violation pulse.

Top module: `ddr_mode_reg_unit`

## Requirements
- R1: When a load arrives while not busy, with bank bits 00 and every bank idle, the mode word becomes {bank, addr} with bit 8 forced to 0, visible the cycle after.
- R2: burst_len decodes mode bits [2:0]: 001 gives 2, 010 gives 4, 011 gives 8, and any other code gives 0, which means reserved.
- R3: burst_interleaved equals mode bit 3: 0 selects sequential ordering and 1 selects interleaved ordering.
- R4: cas_code shows mode bits [6:4] unchanged. Only code 011 (latency 3) counts as supported.
- R5: After an accepted load, cfg_invalid is high if any of the following holds, and the word is stored anyway:
  - the burst code is reserved;
  - the latency code is not 011;
  - bits [13:7] are neither all zero nor 0000010.
- R6: An accepted load with address bit 8 set gives dll_reset_pulse high for exactly one cycle. Mode word bit 8 always reads 0.
- R7: A load with nonzero bank bits, or with any bank_idle bit low, leaves the mode word unchanged and pulses load_error for one cycle.
- R8: An accepted load holds busy high for TMRD-1 cycles, so that a command arriving TMRD cycles after the load is accepted. Rejected loads start no lockout.
- R9: A command (load or other) arriving while busy is ignored and pulses cmd_violation for one cycle.
- R10: Reset clears every output, including the mode word, to 0. cfg_valid rises on the first accepted load and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_load | input | 1 | Decoded mode-load command strobe |
| cmd_other | input | 1 | Strobe for any other decoded command |
| addr | input | 12 | Address bits sampled by a load |
| bank | input | 2 | Bank-select bits; must be 00 for a load |
| bank_idle | input | NUM_BANKS | One bit per bank, high when that bank is idle |
| mode_word | output | 14 | Stored mode word |
| burst_len | output | 4 | Decoded burst length (2, 4 or 8; 0 if reserved) |
| burst_interleaved | output | 1 | Burst ordering, 1 for interleaved |
| cas_code | output | 3 | Stored latency code |
| dll_reset_pulse | output | 1 | One-cycle DLL reset request |
| cfg_valid | output | 1 | At least one load accepted since reset |
| cfg_invalid | output | 1 | Last accepted load held a reserved code |
| load_error | output | 1 | One-cycle pulse on a refused load |
| busy | output | 1 | Lockout after an accepted load is active |
| cmd_violation | output | 1 | One-cycle pulse on a command during lockout |

## Verification
The assertions assume that the command decoder asserts at most one of cmd_load and cmd_other in a cycle. They also assume that addr, bank and bank_idle are meaningful only in a cycle that carries a strobe. The stimulus raises a single strobe per cycle and changes the inputs only on the falling edge. It covers loads with open banks, loads with a bank bit set, and commands placed inside the lockout window, so that both the refusal paths and the acceptance paths are exercised.

// File: rtl/ddr_mr_pkg.sv
package ddr_mr_pkg;
  localparam int ADDR_W  = 12;
  localparam int BA_W    = 2;
  localparam int MR_W    = ADDR_W + BA_W;
  localparam int DLL_BIT = 8;

  typedef logic [MR_W-1:0] mr_word_t;

  localparam logic [2:0] CL_SUPPORTED = 3'b011;
  localparam logic [6:0] OPM_NORMAL   = 7'b0000000;
  localparam logic [6:0] OPM_DLL_RST  = 7'b0000010;

  function automatic logic [3:0] burst_len_of(input logic [2:0] code);
    case (code)
      3'b001:  return 4'd2;
      3'b010:  return 4'd4;
      3'b011:  return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic word_reserved(input mr_word_t w);
    logic bad_len, bad_cl, bad_op;
    bad_len = (burst_len_of(w[2:0]) == 4'd0);
    bad_cl  = (w[6:4] != CL_SUPPORTED);
    bad_op  = (w[13:7] != OPM_NORMAL) && (w[13:7] != OPM_DLL_RST);
    return bad_len | bad_cl | bad_op;
  endfunction
endpackage

// File: rtl/mr_field_decode.sv
module mr_field_decode
  import ddr_mr_pkg::*;
(
  input  mr_word_t   word,
  output logic [3:0] burst_len,
  output logic       interleaved,
  output logic [2:0] cas_code
);
  always_comb begin
    burst_len   = burst_len_of(word[2:0]);
    interleaved = word[3];
    cas_code    = word[6:4];
  end
endmodule

// File: rtl/mr_lockout.sv
module mr_lockout #(
  parameter int TMRD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = (TMRD < 2) ? 1 : $clog2(TMRD + 1);
  localparam logic [CW-1:0] RELOAD = CW'(TMRD - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)               cnt_d = RELOAD;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/ddr_mode_reg_unit.sv
module ddr_mode_reg_unit
  import ddr_mr_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TMRD      = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_load,
  input  logic                 cmd_other,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BA_W-1:0]      bank,
  input  logic [NUM_BANKS-1:0] bank_idle,
  output logic [MR_W-1:0]      mode_word,
  output logic [3:0]           burst_len,
  output logic                 burst_interleaved,
  output logic [2:0]           cas_code,
  output logic                 dll_reset_pulse,
  output logic                 cfg_valid,
  output logic                 cfg_invalid,
  output logic                 load_error,
  output logic                 busy,
  output logic                 cmd_violation
);
  mr_word_t load_word, mode_q, mode_d;
  logic     valid_q, valid_d, inval_q, inval_d;
  logic     dll_q, dll_d, err_q, err_d, viol_q, viol_d;
  logic     load_try, load_ok, load_bad, blocked;

  assign load_word = {bank, addr};
  assign blocked   = busy & (cmd_load | cmd_other);
  assign load_try  = cmd_load & ~busy;
  assign load_ok   = load_try & (bank == '0) & (&bank_idle);
  assign load_bad  = load_try & ~load_ok;

  always_comb begin
    mode_d  = mode_q;
    valid_d = valid_q;
    inval_d = inval_q;
    if (load_ok) begin
      mode_d          = load_word;
      mode_d[DLL_BIT] = 1'b0;
      valid_d         = 1'b1;
      inval_d         = word_reserved(load_word);
    end
    dll_d  = load_ok & load_word[DLL_BIT];
    err_d  = load_bad;
    viol_d = blocked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      valid_q <= 1'b0;
      inval_q <= 1'b0;
      dll_q   <= 1'b0;
      err_q   <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      valid_q <= valid_d;
      inval_q <= inval_d;
      dll_q   <= dll_d;
      err_q   <= err_d;
      viol_q  <= viol_d;
    end
  end

  mr_lockout #(.TMRD(TMRD)) lock_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (load_ok),
    .busy  (busy)
  );

  mr_field_decode dec_i (
    .word        (mode_q),
    .burst_len   (burst_len),
    .interleaved (burst_interleaved),
    .cas_code    (cas_code)
  );

  assign mode_word       = mode_q;
  assign cfg_valid       = valid_q;
  assign cfg_invalid     = inval_q;
  assign dll_reset_pulse = dll_q;
  assign load_error      = err_q;
  assign cmd_violation   = viol_q;
endmodule

// File: rtl/ddr_mode_reg_unit_chk.sv
module ddr_mode_reg_unit_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_load,
  input logic                 cmd_other,
  input logic [11:0]          addr,
  input logic [1:0]           bank,
  input logic [NUM_BANKS-1:0] bank_idle,
  input logic [13:0]          mode_word,
  input logic [3:0]           burst_len,
  input logic                 dll_reset_pulse,
  input logic                 cfg_valid,
  input logic                 load_error,
  input logic                 busy,
  input logic                 cmd_violation
);
  AST_LOAD_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_load && !busy && bank == 2'b00 && (&bank_idle))
      |=> (mode_word == ({2'b00, $past(addr)} & 14'h3EFF)) && cfg_valid); // R1

  AST_BLEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_len == 4'd0) || (burst_len == 4'd2) || (burst_len == 4'd4) || (burst_len == 4'd8)); // R2

  AST_DLL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dll_reset_pulse |=> !dll_reset_pulse); // R6

  AST_DLL_NOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_word[8]); // R6

  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_load && !busy && (bank != 2'b00 || !(&bank_idle)))
      |=> load_error && $stable(mode_word) && !busy); // R7

  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cmd_load || cmd_other)) |=> cmd_violation && $stable(mode_word)); // R9

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> cfg_valid); // R10
endmodule

bind ddr_mode_reg_unit ddr_mode_reg_unit_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .cmd_load        (cmd_load),
  .cmd_other       (cmd_other),
  .addr            (addr),
  .bank            (bank),
  .bank_idle       (bank_idle),
  .mode_word       (mode_word),
  .burst_len       (burst_len),
  .dll_reset_pulse (dll_reset_pulse),
  .cfg_valid       (cfg_valid),
  .load_error      (load_error),
  .busy            (busy),
  .cmd_violation   (cmd_violation)
);

// File: tb/ddr_mode_reg_unit_tb_top.sv
module ddr_mode_reg_unit_tb_top;
  localparam int NB   = 4;
  localparam int TMRD = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_load = 1'b0, cmd_other = 1'b0;
  logic [11:0]   addr = '0;
  logic [1:0]    bank = '0;
  logic [NB-1:0] bank_idle = '1;
  logic [13:0]   mode_word;
  logic [3:0]    burst_len;
  logic [2:0]    cas_code;
  logic          burst_interleaved, dll_reset_pulse, cfg_valid, cfg_invalid;
  logic          load_error, busy, cmd_violation;

  always #2.5 clk = ~clk;

  ddr_mode_reg_unit #(.NUM_BANKS(NB), .TMRD(TMRD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_other(cmd_other),
    .addr(addr), .bank(bank), .bank_idle(bank_idle),
    .mode_word(mode_word), .burst_len(burst_len),
    .burst_interleaved(burst_interleaved), .cas_code(cas_code),
    .dll_reset_pulse(dll_reset_pulse), .cfg_valid(cfg_valid),
    .cfg_invalid(cfg_invalid), .load_error(load_error), .busy(busy),
    .cmd_violation(cmd_violation)
  );

  typedef struct {
    int          due;
    logic [27:0] exp;
    string       tag;
  } item_t;

  item_t queue_q[$];
  int    cyc = 0;
  int    n_checks = 0, n_errors = 0;
  bit    finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // reference model state
  logic [13:0] m_mode = '0;
  bit          m_valid = 0, m_inval = 0;
  int          m_cnt = 0;

  function automatic logic [3:0] ref_len(input logic [2:0] c);
    if (c == 3'd1) return 4'd2;
    if (c == 3'd2) return 4'd4;
    if (c == 3'd3) return 4'd8;
    return 4'd0;
  endfunction

  task automatic step(input bit ld, input bit oth, input logic [11:0] a,
                      input logic [1:0] ba, input logic [NB-1:0] idle, input string tag);
    item_t it;
    bit blk, ok, bad, dll;
    logic [13:0] w;
    @(negedge clk);
    cmd_load = ld; cmd_other = oth; addr = a; bank = ba; bank_idle = idle;
    blk = (m_cnt != 0) && (ld || oth);
    ok  = ld && (m_cnt == 0) && (ba == 2'b00) && (idle == '1);
    bad = ld && (m_cnt == 0) && !ok;
    dll = ok && a[8];
    w = {ba, a};
    if (ok) begin
      m_inval = (ref_len(w[2:0]) == 0) || (w[6:4] != 3'b011) ||
                !((w[13:7] == 7'd0) || (w[13:7] == 7'b0000010));
      m_mode = w; m_mode[8] = 1'b0;
      m_valid = 1;
      m_cnt = TMRD - 1;
    end else if (m_cnt > 0) m_cnt--;
    it.due = cyc + 1;
    it.tag = tag;
    it.exp = {m_mode, ref_len(m_mode[2:0]), m_mode[3], m_mode[6:4],
              dll, m_valid, m_inval, bad, (m_cnt != 0), blk};
    queue_q.push_back(it);
  endtask

  task automatic idle_step(input string tag);
    step(0, 0, 12'h000, 2'b00, '1, tag);
  endtask

  always @(negedge clk) begin
    while (queue_q.size() > 0 && queue_q[0].due == cyc) begin
      item_t it;
      logic [27:0] act;
      it = queue_q.pop_front();
      act = {mode_word, burst_len, burst_interleaved, cas_code, dll_reset_pulse,
             cfg_valid, cfg_invalid, load_error, busy, cmd_violation};
      n_checks++;
      if (act !== it.exp) begin
        n_errors++;
        $display("FAIL %s: actual=%h expected=%h (cycle %0d)", it.tag, act, it.exp, cyc);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_step("R10 reset state");
    step(1, 0, 12'h032, 2'b00, '1, "R1 load BL4 seq CL3");
    step(0, 1, 12'h000, 2'b00, '1, "R9 other cmd in lockout");
    step(1, 0, 12'h03B, 2'b00, '1, "R3 load BL8 interleaved");
    step(1, 0, 12'h031, 2'b00, '1, "R9 load in lockout ignored");
    idle_step("R8 lockout over");
    step(1, 0, 12'h033, 2'b01, '1, "R7 bank bit set");
    step(1, 0, 12'h033, 2'b00, 4'b1101, "R7 bank open");
    step(1, 0, 12'h132, 2'b00, '1, "R6 dll reset load");
    idle_step("R6 pulse ends");
    step(1, 0, 12'h021, 2'b00, '1, "R4 latency code 2 unsupported");
    idle_step("R8 idle");
    step(1, 0, 12'h035, 2'b00, '1, "R2 reserved burst code");
    idle_step("R2 idle");
    step(1, 0, 12'h232, 2'b00, '1, "R5 reserved op bits");
    idle_step("R5 idle");
    step(1, 0, 12'h031, 2'b00, '1, "R2 burst two valid");
    step(0, 0, 12'h000, 2'b00, '1, "R8 busy gone after TMRD");
    step(0, 1, 12'h000, 2'b00, '1, "R8 other cmd accepted");
    idle_step("R10 valid sticky");
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule